// File: doc/BRIEF.md
# Serial Converter Control Front-End

This block is the digital front-end of the serial port on a multichannel successive-approximation converter. A host drives a serial clock, an active-low select and a data line. The block waits for a start bit and collects an 8-bit control word. It decodes the word into an input-multiplexer setting, a polarity flag and a power/clock mode. It times the track and hold phases of the sampling front-end. It then returns a 12-bit conversion result, MSB first, on the serial output.

The analog path is outside this block. The result word comes in on a parallel input from the converter core or a behavioural stub. When the host selects internal-clock conversion, the block only waits for a done input from the core and reports it on the strobe line.

Serial clock, select and data are sampled on a fast system clock. They are assumed to be already synchronised to that clock. Edges of the serial clock are found by comparing each sample with the previous one. Each output is paired with its own enable, so a pad ring can tri-state it.

Top module: `adc_serial_frontend`

## Requirements
- R1: Data is taken only on a rising serial-clock edge while `cs_n` is low. Serial-clock activity while `cs_n` is high has no effect on the parser or on the outputs.
- R2: After `cs_n` falls, any number of 0 bits is skipped. The first 1 is bit 7 of the control word, and the following bits fill it MSB first. Field layout from bit 7 down to bit 0: start, SEL2, SEL1, SEL0, unipolar flag, single-ended flag, PD1, PD0.
- R3: The positive channel is {SEL1,SEL0,SEL2}. When the single-ended flag is 1, `neg_com_o`=1 and `neg_ch_o`=0. When it is 0, `neg_com_o`=0 and `neg_ch_o`={SEL1,SEL0,~SEL2}, the other channel of the same pair.
- R4: `unipolar_o` copies the unipolar flag (1 = straight binary, 0 = two's complement). `pmode_o` copies PD1:PD0 (00 power-down, 01 unassigned, 10 internal clock, 11 external clock). All decoded outputs change on the falling edge after bit 8 and keep their value until the next complete word, including through `cs_n` high.
- R5: `track_o` is high from the falling edge after the 5th control bit until the falling edge after the 8th. `hold_o` rises on that last edge and stays high until `cs_n` rises. The two are never high together.
- R6: In every mode except internal clock (PD1:PD0 ≠ 10), `sstrb` is high for exactly one serial-clock period, starting at the falling edge after bit 8.
- R7: The falling edge that ends the strobe pulse captures `result_i` and puts bit 11 on `dout`. Each following falling edge presents the next lower bit. After bit 0, `dout` shifts zeros until `cs_n` rises.
- R8: `dout` changes only on a falling serial-clock edge, when `cs_n` is high, or on the internal-mode done event of R9.
- R9: In internal clock mode, `sstrb` stays low after bit 8. When `conv_done_i` is seen, `sstrb` goes high, `result_i` is captured with bit 11 on `dout`, and the lower bits follow on the next falling edges.
- R10: While `cs_n` is high, `dout_oe` and `sstrb_oe` are low, `dout`, `sstrb`, `track_o` and `hold_o` are 0, and the parser returns to the start-bit hunt. Once `cs_n` is low, `sstrb_oe` is high and `sstrb` drives 0. Reset gives the same output state.
- R11: A `cs_n` rise in the middle of a control word throws the partial word away. The next word after `cs_n` falls again is parsed from its own start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data from the host |
| result_i | input | RES_BITS | Conversion result from the converter core |
| conv_done_i | input | 1 | Core finished an internal-clock conversion |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Output enable for `sstrb` |
| track_o | output | 1 | Sampler in acquisition |
| hold_o | output | 1 | Sampler holding the sample |
| pos_ch_o | output | 3 | Positive input channel |
| neg_ch_o | output | 3 | Negative input channel in differential mode |
| neg_com_o | output | 1 | Negative input is the common return |
| unipolar_o | output | 1 | Unipolar coding selected |
| pmode_o | output | 2 | Decoded power/clock mode |

## Verification
The bench uses control words that set different channel, differential-polarity and mode bits. This separates a swapped select-bit order from a correct decode, and an internal-clock word from an external-clock word. Each word is preceded by a varying number of zero bits, so an off-by-one in the start-bit hunt shows up as shifted fields and shifted track and hold timing. Random result words, including 0x800, and random data on the line while the result shifts out show whether the capture edge, the MSB order and the zero fill are right. An aborted word followed by clock pulses with the select released shows that no stale state survives into the next word.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

  localparam int CTRL_BITS = 8;
  localparam int CH_BITS   = 3;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CTRL,
    ST_STROBE,
    ST_SHIFT,
    ST_WAIT
  } fe_state_t;

  typedef enum logic [1:0] {
    PM_DOWN = 2'b00,
    PM_RSVD = 2'b01,
    PM_INT  = 2'b10,
    PM_EXT  = 2'b11
  } pmode_t;

  typedef struct packed {
    logic [CH_BITS-1:0] pos;
    logic [CH_BITS-1:0] neg;
    logic               neg_com;
    logic               unipolar;
    pmode_t             pmode;
  } fe_cfg_t;

endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic rise_o,
  output logic fall_o
);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  // Edges count only while the port is selected
  assign rise_o = sclk & ~sclk_q & ~cs_n;
  assign fall_o = ~sclk & sclk_q & ~cs_n;

endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import adc_fe_pkg::*;
(
  input  logic [CTRL_BITS-1:0] word_i,
  output fe_cfg_t              cfg_o
);

  logic sel2, sel1, sel0, single;

  assign sel2   = word_i[6];
  assign sel1   = word_i[5];
  assign sel0   = word_i[4];
  assign single = word_i[2];

  always_comb begin
    cfg_o.pos      = {sel1, sel0, sel2};
    cfg_o.neg_com  = single;
    cfg_o.neg      = single ? '0 : {sel1, sel0, ~sel2};
    cfg_o.unipolar = word_i[3];
    cfg_o.pmode    = pmode_t'(word_i[1:0]);
  end

  // bit 7 is the start marker; the parser guarantees it, nothing to decode
  logic unused_start;
  assign unused_start = word_i[7];

endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [RES_BITS-1:0] word_i,
  output logic                bit_o
);

  logic [RES_BITS-1:0] sr_q, sr_d;
  logic                bit_q, bit_d;

  always_comb begin
    sr_d  = sr_q;
    bit_d = bit_q;
    if (clr_i) begin
      sr_d  = '0;
      bit_d = 1'b0;
    end else if (load_i) begin
      sr_d  = {word_i[RES_BITS-2:0], 1'b0};
      bit_d = word_i[RES_BITS-1];
    end else if (shift_i) begin
      sr_d  = {sr_q[RES_BITS-2:0], 1'b0};
      bit_d = sr_q[RES_BITS-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
    end
  end

  assign bit_o = bit_q;

  assert_load_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (bit_o == $past(word_i[RES_BITS-1])));

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !bit_o);

endmodule

// File: rtl/adc_serial_frontend.sv
module adc_serial_frontend
  import adc_fe_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int TRACK_AT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                din,
  input  logic [RES_BITS-1:0] result_i,
  input  logic                conv_done_i,
  output logic                dout,
  output logic                dout_oe,
  output logic                sstrb,
  output logic                sstrb_oe,
  output logic                track_o,
  output logic                hold_o,
  output logic [CH_BITS-1:0]  pos_ch_o,
  output logic [CH_BITS-1:0]  neg_ch_o,
  output logic                neg_com_o,
  output logic                unipolar_o,
  output logic [1:0]          pmode_o
);

  localparam int CNT_W = $clog2(CTRL_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_TRACK = CNT_W'(TRACK_AT);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CTRL_BITS);

  logic rise, fall;

  sclk_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk),
    .cs_n   (cs_n),
    .rise_o (rise),
    .fall_o (fall)
  );

  fe_state_t            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [CTRL_BITS-1:0] word_q, word_d;
  logic                 track_q, track_d;
  logic                 hold_q, hold_d;
  logic                 sstrb_q, sstrb_d;
  logic                 oe_q, oe_d;
  fe_cfg_t              cfg_q, cfg_d, cfg_dec;
  logic                 sh_clr, sh_load, sh_shift;

  ctrl_decode u_dec (
    .word_i (word_q),
    .cfg_o  (cfg_dec)
  );

  result_shifter #(.RES_BITS(RES_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (sh_clr),
    .load_i  (sh_load),
    .shift_i (sh_shift),
    .word_i  (result_i),
    .bit_o   (dout)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    word_d   = word_q;
    track_d  = track_q;
    hold_d   = hold_q;
    sstrb_d  = sstrb_q;
    cfg_d    = cfg_q;
    oe_d     = 1'b1;
    sh_clr   = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    if (cs_n) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      track_d = 1'b0;
      hold_d  = 1'b0;
      sstrb_d = 1'b0;
      oe_d    = 1'b0;
      sh_clr  = 1'b1;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (rise && din) begin
            word_d  = CTRL_BITS'(1);
            cnt_d   = CNT_W'(1);
            state_d = ST_CTRL;
          end
        end
        ST_CTRL: begin
          if (rise) begin
            word_d = {word_q[CTRL_BITS-2:0], din};
            cnt_d  = cnt_q + 1'b1;
          end else if (fall) begin
            if (cnt_q == CNT_TRACK) track_d = 1'b1;
            if (cnt_q == CNT_LAST) begin
              track_d = 1'b0;
              hold_d  = 1'b1;
              cfg_d   = cfg_dec;
              if (cfg_dec.pmode == PM_INT) begin
                sstrb_d = 1'b0;
                state_d = ST_WAIT;
              end else begin
                sstrb_d = 1'b1;
                state_d = ST_STROBE;
              end
            end
          end
        end
        ST_STROBE: begin
          if (fall) begin
            sstrb_d = 1'b0;
            sh_load = 1'b1;
            state_d = ST_SHIFT;
          end
        end
        ST_WAIT: begin
          if (conv_done_i) begin
            sstrb_d = 1'b1;
            sh_load = 1'b1;
            state_d = ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (fall) sh_shift = 1'b1;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      word_q  <= '0;
      track_q <= 1'b0;
      hold_q  <= 1'b0;
      sstrb_q <= 1'b0;
      oe_q    <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      word_q  <= word_d;
      track_q <= track_d;
      hold_q  <= hold_d;
      sstrb_q <= sstrb_d;
      oe_q    <= oe_d;
      cfg_q   <= cfg_d;
    end
  end

  assign sstrb      = sstrb_q;
  assign sstrb_oe   = oe_q;
  assign dout_oe    = oe_q;
  assign track_o    = track_q;
  assign hold_o     = hold_q;
  assign pos_ch_o   = cfg_q.pos;
  assign neg_ch_o   = cfg_q.neg;
  assign neg_com_o  = cfg_q.neg_com;
  assign unipolar_o = cfg_q.unipolar;
  assign pmode_o    = cfg_q.pmode;

  assert_track_hold_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(track_o && hold_o));

  assert_hold_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(fall));

  assert_strobe_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE) |-> sstrb);

  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE && fall) |=> !sstrb);

  assert_dout_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(fall) || $past(cs_n) ||
                        $past(state_q == ST_WAIT && conv_done_i)));

  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!dout_oe && !sstrb_oe && !track_o && !hold_o && !sstrb &&
              state_q == ST_HUNT));

  assert_cfg_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_CTRL) |=> $stable(pmode_o));

endmodule

// File: tb/adc_serial_frontend_test.sv
module adc_serial_frontend_test;

  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk;
  logic        cs_n;
  logic        din;
  logic [11:0] result;
  logic        conv_done;
  logic        dout, dout_oe, sstrb, sstrb_oe, track_o, hold_o;
  logic [2:0]  pos_ch_o, neg_ch_o;
  logic        neg_com_o, unipolar_o;
  logic [1:0]  pmode_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_serial_frontend uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .din         (din),
    .result_i    (result),
    .conv_done_i (conv_done),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .sstrb       (sstrb),
    .sstrb_oe    (sstrb_oe),
    .track_o     (track_o),
    .hold_o      (hold_o),
    .pos_ch_o    (pos_ch_o),
    .neg_ch_o    (neg_ch_o),
    .neg_com_o   (neg_com_o),
    .unipolar_o  (unipolar_o),
    .pmode_o     (pmode_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected decode: {pos, neg, neg_com, unipolar, pmode}
  function automatic logic [9:0] exp_cfg(input logic [7:0] b);
    logic [2:0] p, n;
    p = {b[5], b[4], b[6]};
    n = b[2] ? 3'd0 : {b[5], b[4], ~b[6]};
    return {p, n, b[2], b[3], b[1:0]};
  endfunction

  function automatic logic [9:0] act_cfg();
    return {pos_ch_o, neg_ch_o, neg_com_o, unipolar_o, pmode_o};
  endfunction

  // One serial clock period; returns after the falling edge has taken effect
  task automatic pulse(input logic d);
    din = d;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_txn(input logic [7:0] cb, input int lead,
                         input logic [11:0] res, input int tail);
    bit ext;
    logic [9:0] cfg_before;
    ext = (cb[1:0] != 2'b10);
    result = res;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "sstrb_oe after select", 32'(sstrb_oe), 32'd1);
    check("R10", "sstrb low after select", 32'(sstrb), 32'd0);
    cfg_before = act_cfg();
    for (int i = 0; i < lead; i++) begin
      pulse(1'b0);
      check("R2", "track during leading zeros", 32'(track_o), 32'd0);
    end
    for (int k = 1; k <= 8; k++) begin
      pulse(cb[8-k]);
      check("R5", "track", 32'(track_o), 32'((k >= 5) && (k < 8)));
      check("R5", "hold", 32'(hold_o), 32'(k == 8));
      if (k < 8) check("R4", "cfg stable mid-word", 32'(act_cfg()), 32'(cfg_before));
      if (k == 8) begin
        check("R6", "strobe after last bit", 32'(sstrb), 32'(ext));
        check("R3", "channel decode", 32'(act_cfg()), 32'(exp_cfg(cb)));
        check("R2", "dout idle before result", 32'(dout), 32'd0);
      end
    end
    if (ext) begin
      for (int j = 1; j <= 12 + tail; j++) begin
        pulse(1'($urandom()));
        check("R7", "result bit", 32'(dout), (j <= 12) ? 32'(res[12-j]) : 32'd0);
        check("R6", "strobe one period", 32'(sstrb), 32'd0);
        check("R5", "hold through result", 32'(hold_o), 32'd1);
      end
    end else begin
      pulse(1'b0);
      pulse(1'b0);
      check("R9", "strobe low while busy", 32'(sstrb), 32'd0);
      check("R9", "dout idle while busy", 32'(dout), 32'd0);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      @(negedge clk);
      check("R9", "strobe high on done", 32'(sstrb), 32'd1);
      check("R9", "msb on done", 32'(dout), 32'(res[11]));
      for (int j = 1; j <= 11 + tail; j++) begin
        pulse(1'b0);
        check("R9", "internal result bit", 32'(dout), (j <= 11) ? 32'(res[11-j]) : 32'd0);
      end
    end
    cfg_before = act_cfg();
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "dout_oe released", 32'(dout_oe), 32'd0);
    check("R10", "sstrb_oe released", 32'(sstrb_oe), 32'd0);
    check("R10", "hold cleared", 32'(hold_o), 32'd0);
    check("R4", "cfg kept after deselect", 32'(act_cfg()), 32'(cfg_before));
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    sclk = 1'b0;
    cs_n = 1'b1;
    din = 1'b0;
    result = '0;
    conv_done = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "reset dout_oe", 32'(dout_oe), 32'd0);
    check("R10", "reset sstrb_oe", 32'(sstrb_oe), 32'd0);
    check("R10", "reset track/hold", 32'({track_o, hold_o}), 32'd0);
    check("R4", "reset pmode", 32'(pmode_o), 32'd0);

    // Directed words
    run_txn(8'b1000_1111, 0, 12'hA5C, 1);  // CH0 single-ended unipolar ext
    run_txn(8'b1111_1111, 3, 12'hFFF, 2);  // CH7 single-ended
    run_txn(8'b1100_0011, 1, 12'h800, 0);  // differential pair 0 reversed, bipolar
    run_txn(8'b1011_0011, 2, 12'h001, 1);  // differential pair 3 direct
    run_txn(8'b1011_1110, 0, 12'h6B3, 2);  // internal clock mode
    run_txn(8'b1110_0100, 4, 12'h3C9, 1);  // power-down mode, ext timing
    run_txn(8'b1001_1001, 1, 12'h555, 0);  // unassigned mode

    // R11: abort mid-word, then R1: clocks while deselected
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    pulse(1'b1);
    pulse(1'b1);
    pulse(1'b0);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "hunt after abort", 32'({track_o, hold_o, sstrb}), 32'd0);
    for (int i = 0; i < 4; i++) begin
      pulse(1'b1);
      check("R1", "no output when deselected", 32'({dout_oe, sstrb_oe, track_o, hold_o}), 32'd0);
    end
    run_txn(8'b1010_0111, 2, 12'h9E4, 1);  // R11: fresh word decodes cleanly

    // Random words
    for (int t = 0; t < 16; t++) begin
      logic [7:0] cb;
      cb = {1'b1, 7'($urandom())};
      run_txn(cb, int'($urandom() % 4), 12'($urandom()), int'($urandom() % 3));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule